// File: doc/BRIEF.md
# Tick Timer with Compare-Event Counter

A free-running 32-bit up-counter that advances on a 1 MHz tick. The tick is made by a prescaler that divides the bus clock by a parameter. The counter is compared with a 32-bit compare value at every tick. A tick that finds the two equal is a compare event.

Optionally, a compare event returns the counter to zero, which turns the timer into a periodic interrupt source. Each event also steps a 4-bit event counter, which software can clear. When the interrupt is armed, an event latches a pending flag. The flag drives an interrupt request at a level that software programs.

Software reaches the block through three write strobes, for counter, compare and control, and reads back through three matching outputs. Address decoding and vector generation live outside the block.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter, compare value, control readback, event count, interrupt request and request level are all zero.
- R2: `tick_o` is high for one clock cycle out of every `CLK_DIV` bus clock cycles, whatever the control settings.
- R3: The counter advances by exactly one per tick while control bit 0 (run) is 1, and holds its value while it is 0.
- R4: A counter write loads `cnt_wdata_i` on that clock edge. It overrides any increment or clear that the same edge would have made, and that edge raises no compare event.
- R5: The compare value is loaded by `cmp_we_i` and reads back on `cmp_o`. A compare event occurs on a tick, while running, when the counter equals the compare value.
- R6: With control bit 1 (restart) set, a compare event loads zero into the counter. With it clear, the counter keeps incrementing past the compare value and wraps from 0xFFFFFFFF to 0.
- R7: The 4-bit event count increments on every compare event and wraps from 15 to 0. A control write with bit 2 set zeroes it, and that clear wins over an event on the same edge.
- R8: A compare event sets the pending flag only while control bit 3 (interrupt arm) is 1. The flag stays set until a control write with bit 4 set. An event on the same edge as that write leaves the flag set.
- R9: `irq_o` equals the pending flag. `irq_lvl_o` shows control bits 7:5 (the request level) while the flag is set and zero otherwise.
- R10: `ctl_o` returns run in bit 0, restart in bit 1, interrupt arm in bit 3, the pending flag in bit 4 and the level in bits 7:5. Bit 2 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 32 | Counter write data |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 32 | Compare write data |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 8 | Control write data; bits 2 and 4 are clear actions |
| cnt_o | output | 32 | Counter value |
| cmp_o | output | 32 | Compare value |
| ctl_o | output | 8 | Control and status readback |
| ovf_cnt_o | output | 4 | Compare-event count |
| tick_o | output | 1 | Prescaled tick enable |
| irq_o | output | 1 | Interrupt request |
| irq_lvl_o | output | 3 | Request level, zero when idle |

## Verification
Every cycle, assertions check the following properties:
- The counter holds when it sees neither a write nor a running tick.
- A write always wins.
- A restart event lands on zero.
- The event count moves by exactly one per unblocked event.
- The pending flag only falls on a clear.
- A nonzero level never appears without a request.

Only the bench scenarios can show the timing and the mode interplay:
- the exact tick spacing;
- the number of counts after a given number of ticks;
- the event period with restart on and off, and the 32-bit wrap;
- the event-count wrap from 15;
- the outcome when a clear lands on the same edge as an event.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
  localparam int unsigned CTL_W       = 8;
  localparam int unsigned LVL_W       = 3;
  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_RESTART = 1;
  localparam int unsigned CTL_OVF_CLR = 2;
  localparam int unsigned CTL_ARM     = 3;
  localparam int unsigned CTL_IRQ_CLR = 4;
  localparam int unsigned CTL_LVL_LSB = 5;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             arm;
    logic             restart;
    logic             run;
  } ctl_t;
endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler #(
  parameter int unsigned CLK_DIV = 33
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(CLK_DIV);
      localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      end

      assign tick_o = (div_q == LAST);

      assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tick_count.sv
`timescale 1ns/1ps
module tick_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             event_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step    = run_i & tick_i & ~we_i;
  assign event_o = step & (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (we_i)                   cnt_q <= wdata_i;
    else if (event_o && restart_i)   cnt_q <= '0;
    else if (step)                   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !(run_i && tick_i)) |=> $stable(cnt_o));
  assert_write_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_o == $past(wdata_i)));
  assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && restart_i) |=> (cnt_o == '0));
endmodule

// File: rtl/tick_event_log.sv
`timescale 1ns/1ps
module tick_event_log #(
  parameter int unsigned OVF_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic             arm_i,
  input  logic             ovf_clr_i,
  input  logic             irq_clr_i,
  output logic [OVF_W-1:0] ovf_o,
  output logic             pend_o
);
  logic [OVF_W-1:0] ovf_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= '0;
    else if (ovf_clr_i) ovf_q <= '0;
    else if (event_i)   ovf_q <= ovf_q + 1'b1;
  end

  // set beats clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (event_i && arm_i)   pend_q <= 1'b1;
    else if (irq_clr_i)          pend_q <= 1'b0;
  end

  assign ovf_o  = ovf_q;
  assign pend_o = pend_q;

  assert_ovf_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !ovf_clr_i) |=> (ovf_o == $past(ovf_o) + OVF_W'(1)));
  assert_ovf_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i |=> (ovf_o == '0));
  assert_pend_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && arm_i) |=> pend_o);
  assert_pend_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !irq_clr_i) |=> pend_o);
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CLK_DIV = 33,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned OVF_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic [OVF_W-1:0] ovf_cnt_o,
  output logic             tick_o,
  output logic             irq_o,
  output logic [LVL_W-1:0] irq_lvl_o
);
  ctl_t             ctl_q;
  logic [CNT_W-1:0] cmp_q;
  logic             tick;
  logic             event_hit;
  logic             pend;
  logic             ovf_clr;
  logic             irq_clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q.run     <= ctl_wdata_i[CTL_RUN];
      ctl_q.restart <= ctl_wdata_i[CTL_RESTART];
      ctl_q.arm     <= ctl_wdata_i[CTL_ARM];
      ctl_q.lvl     <= ctl_wdata_i[CTL_LVL_LSB +: LVL_W];
    end
  end

  assign ovf_clr = ctl_we_i & ctl_wdata_i[CTL_OVF_CLR];
  assign irq_clr = ctl_we_i & ctl_wdata_i[CTL_IRQ_CLR];

  tick_prescaler #(.CLK_DIV(CLK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tick_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .run_i     (ctl_q.run),
    .restart_i (ctl_q.restart),
    .we_i      (cnt_we_i),
    .wdata_i   (cnt_wdata_i),
    .cmp_i     (cmp_q),
    .cnt_o     (cnt_o),
    .event_o   (event_hit)
  );

  tick_event_log #(.OVF_W(OVF_W)) u_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .event_i   (event_hit),
    .arm_i     (ctl_q.arm),
    .ovf_clr_i (ovf_clr),
    .irq_clr_i (irq_clr),
    .ovf_o     (ovf_cnt_o),
    .pend_o    (pend)
  );

  always_comb begin
    ctl_o                          = '0;
    ctl_o[CTL_RUN]                 = ctl_q.run;
    ctl_o[CTL_RESTART]             = ctl_q.restart;
    ctl_o[CTL_ARM]                 = ctl_q.arm;
    ctl_o[CTL_IRQ_CLR]             = pend;
    ctl_o[CTL_LVL_LSB +: LVL_W]    = ctl_q.lvl;
  end

  assign cmp_o     = cmp_q;
  assign tick_o    = tick;
  assign irq_o     = pend;
  assign irq_lvl_o = pend ? ctl_q.lvl : '0;

  assert_lvl_needs_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lvl_o != '0) |-> irq_o);
  assert_no_event_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_q.run |-> !event_hit);
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  localparam int DIV = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_we_i = 1'b0, cmp_we_i = 1'b0, ctl_we_i = 1'b0;
  logic [31:0] cnt_wdata_i = '0, cmp_wdata_i = '0;
  logic [7:0]  ctl_wdata_i = '0;
  logic [31:0] cnt_o, cmp_o;
  logic [7:0]  ctl_o;
  logic [3:0]  ovf_cnt_o;
  logic        tick_o, irq_o;
  logic [2:0]  irq_lvl_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tick_timer #(.CLK_DIV(DIV)) u_dut (
    .clk_i, .rst_ni, .cnt_we_i, .cnt_wdata_i, .cmp_we_i, .cmp_wdata_i,
    .ctl_we_i, .ctl_wdata_i, .cnt_o, .cmp_o, .ctl_o, .ovf_cnt_o,
    .tick_o, .irq_o, .irq_lvl_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_tick();
    do @(negedge clk_i); while (!tick_o);
  endtask

  task automatic wr_cnt(input logic [31:0] v);
    cnt_we_i = 1'b1; cnt_wdata_i = v;
    @(negedge clk_i); cnt_we_i = 1'b0;
  endtask

  task automatic wr_cmp(input logic [31:0] v);
    cmp_we_i = 1'b1; cmp_wdata_i = v;
    @(negedge clk_i); cmp_we_i = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk_i); ctl_we_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt_o, 0);
    chk("R1 cmp", cmp_o, 0);
    chk("R1 ctl", {24'd0, ctl_o}, 0);
    chk("R1 ovf", {28'd0, ovf_cnt_o}, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 lvl", {29'd0, irq_lvl_o}, 0);
  endtask

  task automatic t_tick_spacing();
    int n = 0;
    wait_tick();
    do begin @(negedge clk_i); n++; end while (!tick_o);
    chk("R2 tick period", n, DIV);
  endtask

  task automatic t_run_hold();
    logic [31:0] held;
    wr_cmp(32'hFFFF_0000);
    wr_cnt(32'd0);
    wr_ctl(8'h01);
    wait_cyc(10 * DIV);
    chk("R3 ten ticks", cnt_o, 10);
    wr_ctl(8'h00);
    held = cnt_o;
    wait_cyc(3 * DIV);
    chk("R3 hold when stopped", cnt_o, held);
  endtask

  task automatic t_write_priority();
    wr_ctl(8'h01);
    wait_tick();
    cnt_we_i = 1'b1; cnt_wdata_i = 32'd100;
    @(negedge clk_i); cnt_we_i = 1'b0;
    chk("R4 write beats increment", cnt_o, 100);
    wait_cyc(DIV);
    chk("R4 resumes after write", cnt_o, 101);
  endtask

  task automatic t_restart();
    wr_ctl(8'h14);
    wr_cnt(32'd18);
    wr_cmp(32'd20);
    chk("R5 cmp readback", cmp_o, 20);
    wr_ctl(8'hAB);
    chk("R10 ctl readback", {24'd0, ctl_o}, 32'hAB);
    wait_cyc(2 * DIV);
    chk("R5 before match", cnt_o, 20);
    chk("R8 no irq before match", {31'd0, irq_o}, 0);
    wait_cyc(DIV);
    chk("R6 restart to zero", cnt_o, 0);
    chk("R7 one event", {28'd0, ovf_cnt_o}, 1);
    chk("R8 irq set", {31'd0, irq_o}, 1);
    chk("R9 level shown", {29'd0, irq_lvl_o}, 5);
    chk("R10 pending readback", {24'd0, ctl_o}, 32'hBB);
    wait_cyc(DIV);
    chk("R8 irq sticky", {31'd0, irq_o}, 1);
    wr_ctl(8'hB8);
    chk("R8 irq cleared", {31'd0, irq_o}, 0);
    chk("R9 level idle", {29'd0, irq_lvl_o}, 0);
  endtask

  task automatic t_no_restart();
    wr_ctl(8'h14);
    wr_cnt(32'd18);
    wr_cmp(32'd20);
    wr_ctl(8'h01);
    wait_cyc(3 * DIV);
    chk("R6 passes compare", cnt_o, 21);
    chk("R7 event counted", {28'd0, ovf_cnt_o}, 1);
    chk("R8 unarmed no irq", {31'd0, irq_o}, 0);
    wr_ctl(8'h04);
    wr_cnt(32'hFFFF_FFFF);
    wr_cmp(32'd5);
    wr_ctl(8'h01);
    wait_cyc(DIV);
    chk("R6 32-bit wrap", cnt_o, 0);
  endtask

  task automatic t_ovf_wrap();
    wr_ctl(8'h14);
    wr_cnt(32'd0);
    wr_cmp(32'd0);
    wr_ctl(8'h03);
    wait_cyc(15 * DIV);
    chk("R7 count 15", {28'd0, ovf_cnt_o}, 15);
    wait_cyc(DIV);
    chk("R7 wrap to 0", {28'd0, ovf_cnt_o}, 0);
    wait_cyc(DIV);
    chk("R7 after wrap", {28'd0, ovf_cnt_o}, 1);
    wait_tick();
    ctl_we_i = 1'b1; ctl_wdata_i = 8'h07;
    @(negedge clk_i); ctl_we_i = 1'b0;
    chk("R7 clear beats event", {28'd0, ovf_cnt_o}, 0);
    chk("R10 clear bit reads 0", {24'd0, ctl_o}, 32'h03);
  endtask

  task automatic t_irq_set_wins();
    wr_ctl(8'h14);
    wr_cnt(32'd0);
    wr_cmp(32'd0);
    wr_ctl(8'h6B);
    wait_tick();
    ctl_we_i = 1'b1; ctl_wdata_i = 8'h7B;
    @(negedge clk_i); ctl_we_i = 1'b0;
    chk("R8 set beats clear", {31'd0, irq_o}, 1);
    wr_ctl(8'h7B);
    chk("R8 clear off tick", {31'd0, irq_o}, 0);
    chk("R9 level idle", {29'd0, irq_lvl_o}, 0);
    wait_cyc(DIV);
    chk("R9 level three", {29'd0, irq_lvl_o}, 3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_ni = 1'b1;
    wait_cyc(2);
    t_reset();
    t_tick_spacing();
    t_run_hold();
    t_write_priority();
    t_restart();
    t_no_restart();
    t_ovf_wrap();
    t_irq_set_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule